// File: doc/BRIEF.md
# UART Interrupt Source Arbiter

This block decides which interrupt cause a 16550-style serial register set reports to the host. It holds the interrupt enable register and a sticky "transmitter ready" event. From these and three live status inputs (receive overrun, receive data available and the four modem-status change bits) it drives a single interrupt request line and the byte that a read of the interrupt identification register returns.

Only one cause is reported at a time, chosen by fixed priority among the causes whose enable bit is set. The transmitter-ready cause is an event, not a level. Each write to the transmit data register arms it. An identification read that reports it disarms it, so software sees it once per write. The request line and the identification byte are combinational from the stored state and the live inputs, so they follow any change within the same cycle.

Top module: `uirq_ident`

## Requirements
- R1: After a synchronous reset the enable register reads 0x00, the transmitter-ready event is cleared, `irq` is low and the identification byte is 0x01 while FIFO mode is off.
- R2: A write to the enable register stores data bits 3:0. Bits 7:4 of the readback are always zero. The enable bits are: bit 0 receive data, bit 1 transmitter ready, bit 2 line status, bit 3 modem status.
- R3: An overrun with enable bit 2 set gives identification bits 3:0 = 0110 (cause code 011), whatever other causes are active.
- R4: Receive data available with enable bit 0 set, and no enabled overrun, gives bits 3:0 = 0100 (code 010).
- R5: A pending transmitter-ready event with enable bit 1 set, and no higher enabled cause, gives bits 3:0 = 0010 (code 001).
- R6: Any modem-status change bit with enable bit 3 set, and no higher enabled cause, gives bits 3:0 = 0000 (code 000).
- R7: With no enabled cause active, bits 3:0 read 0001 and `irq` is low. Whenever any cause is reported, `irq` is high and bit 0 is 0.
- R8: A pulse on `thr_wr` arms the transmitter-ready event from the next cycle on.
- R9: An identification read in a cycle whose reported cause is transmitter ready disarms the event for the next cycle. An identification read that reports any other cause, or no cause, leaves the event as it was.
- R10: When a transmit write and a disarming identification read fall in the same cycle, the event stays armed.
- R11: Identification bits 7:6 read 11 when `fifo_en` is high and 00 otherwise. Bits 5:4 always read 00.
- R12: `irq` and the identification byte respond in the same cycle to changes of the status inputs and of the stored enables, without an added register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_wr | input | 1 | Write strobe for the enable register |
| wdata | input | 8 | Write data for the enable register |
| thr_wr | input | 1 | Strobe marking a transmit data register write |
| iir_rd | input | 1 | Strobe marking an identification register read |
| fifo_en | input | 1 | FIFO mode is enabled |
| overrun | input | 1 | Receive overrun flag |
| rx_avail | input | 1 | Receive data available |
| msr_delta | input | 4 | Modem-status change bits |
| irq | output | 1 | Interrupt request |
| iir_val | output | 8 | Identification register value |
| ier_val | output | 8 | Enable register readback |

## Verification
The assertions assume that every strobe is a single-cycle level sampled at the clock edge. They also assume that an identification read's side effect is decided by the cause reported in that same cycle, so the status inputs must not be changed between the read and the edge. The bench changes every input only on the falling edge and holds it through the rising edge. It compares against a behavioural model just before each rising edge. This makes it legal to raise `thr_wr` and `iir_rd` together, and to change the flags on any cycle, and the model still sees the same cause the hardware acts on.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int N_CAUSE = 4;
  localparam int SEL_W   = $clog2(N_CAUSE);
  localparam int CODE_W  = 3;

  // enable register bit positions
  localparam int EN_RX    = 0;
  localparam int EN_THRE  = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  // arbitration slots, slot 0 is the highest priority
  localparam int SLOT_LINE  = 0;
  localparam int SLOT_RX    = 1;
  localparam int SLOT_THRE  = 2;
  localparam int SLOT_MODEM = 3;

  typedef enum logic [CODE_W-1:0] {
    CODE_MODEM = 3'b000,
    CODE_THRE  = 3'b001,
    CODE_RX    = 3'b010,
    CODE_LINE  = 3'b011
  } cause_code_e;

  function automatic cause_code_e code_of(input logic [SEL_W-1:0] slot);
    case (slot)
      SEL_W'(SLOT_LINE): code_of = CODE_LINE;
      SEL_W'(SLOT_RX):   code_of = CODE_RX;
      SEL_W'(SLOT_THRE): code_of = CODE_THRE;
      default:           code_of = CODE_MODEM;
    endcase
  endfunction
endpackage

// File: rtl/uirq_enable_reg.sv
module uirq_enable_reg #(
  parameter int DW   = 8,
  parameter int EN_W = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam logic [DW-1:0] KEEP = DW'((1 << EN_W) - 1);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (wr) q <= wdata & KEEP;
  end
endmodule

// File: rtl/uirq_event_flag.sv
module uirq_event_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic pend
);
  // a new event in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (rst)      pend <= 1'b0;
    else if (set) pend <= 1'b1;
    else if (clr) pend <= 1'b0;
  end
endmodule

// File: rtl/uirq_arbiter.sv
module uirq_arbiter #(
  parameter int N = 4,
  localparam int SW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [SW-1:0] sel
);
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        sel = SW'(i);
      end
    end
  end
endmodule

// File: rtl/uirq_ident.sv
module uirq_ident
  import uirq_pkg::*;
#(
  parameter int DW   = 8,
  parameter int EN_W = 4,
  parameter int MS_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ier_wr,
  input  logic [DW-1:0]   wdata,
  input  logic            thr_wr,
  input  logic            iir_rd,
  input  logic            fifo_en,
  input  logic            overrun,
  input  logic            rx_avail,
  input  logic [MS_W-1:0] msr_delta,
  output logic            irq,
  output logic [DW-1:0]   iir_val,
  output logic [DW-1:0]   ier_val
);
  logic [N_CAUSE-1:0] req;
  logic               hit;
  logic [SEL_W-1:0]   sel;
  logic               thre_pend;
  logic               thre_clr;
  cause_code_e        code;

  uirq_enable_reg #(.DW(DW), .EN_W(EN_W)) u_en (
    .clk(clk), .rst(rst), .wr(ier_wr), .wdata(wdata), .q(ier_val)
  );

  assign req[SLOT_LINE]  = overrun      & ier_val[EN_LINE];
  assign req[SLOT_RX]    = rx_avail     & ier_val[EN_RX];
  assign req[SLOT_THRE]  = thre_pend    & ier_val[EN_THRE];
  assign req[SLOT_MODEM] = (|msr_delta) & ier_val[EN_MODEM];

  uirq_arbiter #(.N(N_CAUSE)) u_arb (.req(req), .hit(hit), .sel(sel));

  assign thre_clr = iir_rd & hit & (sel == SEL_W'(SLOT_THRE));

  uirq_event_flag u_thre (
    .clk(clk), .rst(rst), .set(thr_wr), .clr(thre_clr), .pend(thre_pend)
  );

  assign code = hit ? code_of(sel) : CODE_MODEM;
  assign irq  = hit;

  always_comb begin
    iir_val      = '0;
    iir_val[0]   = ~hit;
    iir_val[3:1] = code;
    iir_val[7:6] = {2{fifo_en}};
  end
endmodule

// File: rtl/uirq_ident_chk.sv
module uirq_ident_chk (
  input logic       clk,
  input logic       rst,
  input logic       thr_wr,
  input logic       iir_rd,
  input logic       fifo_en,
  input logic       overrun,
  input logic       irq,
  input logic [7:0] iir_val,
  input logic [7:0] ier_val,
  input logic       thre_pend
);
  logic thre_reported;
  assign thre_reported = (iir_val[3:0] == 4'b0010);

  assert_ier_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    ier_val[7:4] == 4'h0);

  assert_overrun_first_R3: assert property (@(posedge clk) disable iff (rst)
    (overrun && ier_val[2]) |-> iir_val[3:0] == 4'b0110);

  assert_irq_vs_bit0_R7: assert property (@(posedge clk) disable iff (rst)
    irq == !iir_val[0]);

  assert_arm_on_write_R8: assert property (@(posedge clk) disable iff (rst)
    thr_wr |=> thre_pend);

  assert_disarm_on_read_R9: assert property (@(posedge clk) disable iff (rst)
    (iir_rd && thre_reported && !thr_wr) |=> !thre_pend);

  assert_hold_otherwise_R9: assert property (@(posedge clk) disable iff (rst)
    (!thr_wr && !(iir_rd && thre_reported)) |=> $stable(thre_pend));

  assert_fifo_bits_R11: assert property (@(posedge clk) disable iff (rst)
    iir_val[7:6] == {2{fifo_en}} && iir_val[5:4] == 2'b00);
endmodule

bind uirq_ident uirq_ident_chk u_chk (
  .clk(clk), .rst(rst), .thr_wr(thr_wr), .iir_rd(iir_rd),
  .fifo_en(fifo_en), .overrun(overrun), .irq(irq), .iir_val(iir_val),
  .ier_val(ier_val), .thre_pend(thre_pend)
);

// File: tb/test_uirq_ident.sv
`timescale 1ns/1ps
module test_uirq_ident;
  logic       clk = 1'b0;
  logic       rst, ier_wr, thr_wr, iir_rd, fifo_en, overrun, rx_avail;
  logic [7:0] wdata;
  logic [3:0] msr_delta;
  logic       irq;
  logic [7:0] iir_val, ier_val;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  // reference state
  int m_ier  = 0;
  bit m_thre = 0;

  always #4 clk = ~clk;

  uirq_ident i_uirq_ident (
    .clk(clk), .rst(rst), .ier_wr(ier_wr), .wdata(wdata), .thr_wr(thr_wr),
    .iir_rd(iir_rd), .fifo_en(fifo_en), .overrun(overrun), .rx_avail(rx_avail),
    .msr_delta(msr_delta), .irq(irq), .iir_val(iir_val), .ier_val(ier_val)
  );

  function automatic int exp_code();
    // returns 0..3 as cause code, -1 for none
    if (overrun && m_ier[2])                 return 3;
    if (rx_avail && m_ier[0])                return 2;
    if (m_thre && m_ier[1])                  return 1;
    if ((msr_delta != 0) && m_ier[3])        return 0;
    return -1;
  endfunction

  function automatic int exp_iir();
    int c = exp_code();
    int v = fifo_en ? 8'hC0 : 8'h00;
    if (c < 0) v = v | 1;
    else       v = v | (c << 1);
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", tag, act, expv, cycles);
    end
  endtask

  // compare outputs against the model; tag names the requirement in focus
  task automatic compare(input string tag);
    int ei = exp_iir();
    check(iir_val == 8'(ei), tag, iir_val, ei);
    check(irq == (exp_code() >= 0), "R7", irq, exp_code() >= 0);
    check(ier_val == 8'(m_ier), "R2", ier_val, m_ier);
  endtask

  // inputs already set after a falling edge; compare, then advance model over the rising edge
  task automatic step(input string tag);
    int c;
    #1;
    compare(tag);
    c = exp_code();
    @(posedge clk);
    if (rst) begin
      m_ier = 0; m_thre = 0;
    end else begin
      if (iir_rd && c == 1) m_thre = 0;
      if (thr_wr) m_thre = 1;
      if (ier_wr) m_ier = wdata & 8'h0F;
    end
    @(negedge clk);
    cycles++;
    ier_wr = 0; thr_wr = 0; iir_rd = 0; rst = 0;
  endtask

  initial begin
    #1_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1; ier_wr = 0; thr_wr = 0; iir_rd = 0; fifo_en = 0;
    overrun = 0; rx_avail = 0; msr_delta = 0; wdata = 0;
    @(negedge clk);
    step("R1");
    // R1: reset state
    #1;
    check(iir_val == 8'h01, "R1", iir_val, 8'h01);
    check(irq == 1'b0, "R1", irq, 0);
    // R2: upper enable bits dropped
    ier_wr = 1; wdata = 8'hFF; step("R2");
    #1; check(ier_val == 8'h0F, "R2", ier_val, 8'h0F);
    // R8: transmit write arms, reported with enable bit 1 (R5)
    thr_wr = 1; step("R8");
    #1; check(iir_val[3:0] == 4'b0010, "R8", iir_val, 4'b0010);
    // R5 above modem change
    msr_delta = 4'b0100; step("R5");
    // R4 receive data above transmitter ready
    rx_avail = 1; step("R4");
    // R3 overrun above all; R12 same-cycle response
    overrun = 1; #1;
    check(iir_val[3:0] == 4'b0110, "R12", iir_val, 4'b0110);
    step("R3");
    // R9: read reporting line status leaves the event armed
    iir_rd = 1; step("R9");
    overrun = 0; rx_avail = 0; step("R9");
    #1; check(iir_val[3:0] == 4'b0010, "R9", iir_val, 4'b0010);
    // R10: write and disarming read together
    iir_rd = 1; thr_wr = 1; step("R10");
    #1; check(iir_val[3:0] == 4'b0010, "R10", iir_val, 4'b0010);
    // R9: disarming read, then modem change shows (R6)
    iir_rd = 1; step("R9");
    #1; check(iir_val[3:0] == 4'b0000, "R6", iir_val, 4'b0000);
    check(irq == 1'b1, "R6", irq, 1);
    // R11: fifo bits
    fifo_en = 1; step("R11");
    #1; check(iir_val == 8'hC0, "R11", iir_val, 8'hC0);
    // R7: disable everything, causes stay active
    ier_wr = 1; wdata = 8'hF0; overrun = 1; rx_avail = 1; thr_wr = 1; step("R7");
    step("R7");
    #1; check(iir_val[3:0] == 4'b0001 && irq == 0, "R7", iir_val, 8'hC1);
    // R12: enabling receive data raises irq in the cycle after the write edge
    ier_wr = 1; wdata = 8'h01; overrun = 0; step("R12");
    #1; check(irq == 1'b1, "R12", irq, 1);
    // mixed stimulus against the model
    for (int k = 0; k < 3000; k++) begin
      ier_wr    = ($urandom % 8) == 0;
      wdata     = 8'($urandom);
      thr_wr    = ($urandom % 4) == 0;
      iir_rd    = ($urandom % 3) == 0;
      fifo_en   = ($urandom % 2) == 0;
      overrun   = ($urandom % 5) == 0;
      rx_avail  = ($urandom % 3) == 0;
      msr_delta = (($urandom % 3) == 0) ? 4'($urandom) : 4'h0;
      rst       = ($urandom % 500) == 0;
      step("R3/R4/R5/R6");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule